// File: doc/BRIEF.md
# Dual-Address DMA Channel

A single DMA channel that moves a block of data by dual-address transfers. Every unit of the block costs two bus cycles: a read at the source address, then a write at the destination address. The unit read is held in an internal register between the two cycles. A bus-ready handshake can stretch either cycle. The memory bus is 32 bits wide and has byte enables. For byte and halfword units the engine extracts the unit from the byte lanes of the source address and steers it onto the lanes of the destination address.

Software programs a source address, a destination address, a 24-bit byte count and a mode word through a small synchronous register port. Setting the enable bit in the mode word starts the block, but only if the configuration is consistent. A bad configuration raises an error flag and no bus cycle is made. In free-running mode the units follow each other back to back. In cycle-steal mode the engine moves exactly one unit for each rising edge of the external request. When the count reaches zero the engine sets a done flag and, when enabled, raises a completion interrupt. Writing the done bit in the status register clears done and any configuration error.

Register index (reg_addr_i): 0 source address, 1 destination address, 2 byte count, 3 mode, 4 status. Mode bits: [1:0] unit size, [2] source increments, [3] destination increments, [4] cycle-steal, [5] interrupt enable, [6] enable. Status bits: [0] done, [1] configuration error, [2] busy.

Top module: `dma_dual_chan`

## Requirements
- R1: After reset all registers read as zero, bus_req_o is low and irq_o is low.
- R2: Each unit is a read cycle (bus_we_o=0) at the source address followed by a write cycle (bus_we_o=1) at the destination address. A cycle holds its address and direction until bus_rdy_i is high.
- R3: Unit size code 0 is 32-bit (4 bytes), 1 is 8-bit (1 byte) and 2 is 16-bit (2 bytes). An incrementing address advances by the unit size after each unit. A static address does not change.
- R4: Byte lanes are little-endian: lane k carries bits [8k+7:8k] and the byte at address a uses lane a[1:0]. The read unit is taken from the lanes of the source address. On the write, bus_be_o enables exactly the destination lanes, and bus_wdata_o carries the unit repeated in every unit-sized slot.
- R5: The count decreases by the unit size after each unit and reads 0 at the end. Done (status bit 0) is set when the last unit's write completes.
- R6: The count is 24 bits wide. Written bits 31:24 are ignored and read back as zero.
- R7: A start is refused and the configuration error (status bit 1) is set, with no bus cycle, if any of these holds: size code 3, a count of zero, a count that is not a multiple of the unit size, or a source or destination address misaligned for the unit size.
- R8: In cycle-steal mode (mode bit 4) the engine moves exactly one unit for each rising edge of ext_req_i, and no unit without one.
- R9: Writing the mode register with enable 0 while busy lets the current unit finish and then stops. No later request moves data, and done stays 0.
- R10: irq_o is high exactly when done is set and the interrupt is enabled (mode bit 5). Writing status with bit 0 set clears done and the configuration error.
- R11: While busy, writes to the source, destination and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ext_req_i | input | 1 | External transfer request |
| bus_req_o | output | 1 | Bus cycle active |
| bus_we_o | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr_o | output | 32 | Byte address of the cycle |
| bus_be_o | output | 4 | Byte enables of the write cycle |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with bus_rdy_i |
| bus_rdy_i | input | 1 | Bus cycle completes |
| irq_o | output | 1 | Completion interrupt |

## Verification
The main function is run with three patterns. The first is a word block with both addresses incrementing and no wait states, which checks cycle order, address stepping and count decrement. The second is a byte block from an odd source address to a static destination with wait states, which shows whether the lane steering, the byte enables and the stretched cycles are right. The third is a halfword block that crosses a word boundary on both sides, which separates upper-half from lower-half lane selection. Cycle-steal runs with spaced request pulses show one unit per edge and none in between. Each configuration-error case is tried alone, so that each refused start can be traced to one rule.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_LINE = 2'd3
  } unit_sz_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RD,
    ST_WR
  } xfer_st_e;

  typedef struct packed {
    logic     enable;
    logic     irq_en;
    logic     steal;
    logic     dst_inc;
    logic     src_inc;
    unit_sz_e size;
  } mode_t;

  localparam int MODE_W = 7;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_MODE = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;

  function automatic logic [2:0] unit_bytes(unit_sz_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          busy_i,
  input  logic          unit_done_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output mode_t         mode_o,
  output logic          start_o,
  output logic          last_o,
  output logic          err_o,
  output logic          irq_o
);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  mode_t         mode_q;
  logic          done_q, err_q;

  mode_t         wr_mode;
  logic [CW-1:0] wr_cmask, step;
  logic [AW-1:0] wr_amask, astep;
  logic          mode_wr, stat_clr, go_wr, cfg_bad;

  assign wr_mode  = mode_t'(reg_wdata_i[MODE_W-1:0]);
  assign wr_cmask = CW'(unit_bytes(wr_mode.size)) - CW'(1);
  assign wr_amask = AW'(unit_bytes(wr_mode.size)) - AW'(1);
  assign step     = CW'(unit_bytes(mode_q.size));
  assign astep    = AW'(unit_bytes(mode_q.size));

  assign mode_wr  = reg_we_i && (reg_addr_i == RA_MODE);
  assign stat_clr = reg_we_i && (reg_addr_i == RA_STAT) && reg_wdata_i[0];
  assign go_wr    = mode_wr && wr_mode.enable && !busy_i && !err_q;
  assign cfg_bad  = (wr_mode.size == SZ_LINE) || (cnt_q == '0) ||
                    (|(cnt_q & wr_cmask)) || (|(src_q & wr_amask)) ||
                    (|(dst_q & wr_amask));
  assign start_o  = go_wr && !cfg_bad;
  assign last_o   = (cnt_q == step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (unit_done_i) begin
        cnt_q <= cnt_q - step;
        if (mode_q.src_inc) src_q <= src_q + astep;
        if (mode_q.dst_inc) dst_q <= dst_q + astep;
      end else if (reg_we_i && !busy_i) begin
        case (reg_addr_i)
          RA_SRC:  src_q <= AW'(reg_wdata_i);
          RA_DST:  dst_q <= AW'(reg_wdata_i);
          RA_CNT:  cnt_q <= reg_wdata_i[CW-1:0];
          default: ;
        endcase
      end

      if (mode_wr) begin
        if (busy_i) begin
          mode_q.enable <= wr_mode.enable;
        end else begin
          mode_q        <= wr_mode;
          mode_q.enable <= start_o;
        end
      end

      if (unit_done_i && last_o) done_q <= 1'b1;
      else if (start_o || stat_clr) done_q <= 1'b0;

      if (go_wr && cfg_bad) err_q <= 1'b1;
      else if (stat_clr)    err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_SRC:  reg_rdata_o = DW'(src_q);
      RA_DST:  reg_rdata_o = DW'(dst_q);
      RA_CNT:  reg_rdata_o = DW'(cnt_q);
      RA_MODE: reg_rdata_o = DW'(mode_q);
      RA_STAT: reg_rdata_o = DW'({busy_i, err_q, done_q});
      default: reg_rdata_o = '0;
    endcase
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;
  assign irq_o  = done_q && mode_q.irq_en;

  // R5: the count only falls while a block runs
  assert_cnt_no_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cnt_q <= $past(cnt_q)));

  // R5: done appears only with the final write
  assert_done_on_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(unit_done_i && last_o));

  // R11: address registers are frozen while busy
  assert_frozen_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !unit_done_i) |=> ($stable(src_q) && $stable(dst_q)));

endmodule

// File: rtl/dma_lane_align.sv
module dma_lane_align
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  unit_sz_e      size_i,
  input  logic [LW-1:0] rd_lane_i,
  input  logic [LW-1:0] wr_lane_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic [DW-1:0] hold_i,
  output logic [DW-1:0] rd_unit_o,
  output logic [DW-1:0] wdata_o,
  output logic [NL-1:0] be_o
);

  logic [DW-1:0] shifted;

  assign shifted = bus_rdata_i >> {rd_lane_i, 3'b000};

  always_comb begin
    case (size_i)
      SZ_BYTE: rd_unit_o = DW'(shifted[7:0]);
      SZ_HALF: rd_unit_o = DW'(shifted[15:0]);
      default: rd_unit_o = shifted;
    endcase
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_e;
    always_comb begin
      case (size_i)
        SZ_BYTE: begin
          lane_d = hold_i[7:0];
          lane_e = (int'(wr_lane_i) == i);
        end
        SZ_HALF: begin
          lane_d = hold_i[8*(i%2) +: 8];
          lane_e = ((int'(wr_lane_i) / 2) == (i / 2));
        end
        default: begin
          lane_d = hold_i[8*(i%4) +: 8];
          lane_e = ((int'(wr_lane_i) / 4) == (i / 4));
        end
      endcase
    end
    assign wdata_o[8*i +: 8] = lane_d;
    assign be_o[i]           = lane_e;
  end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          enable_i,
  input  logic          steal_i,
  input  logic          last_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          ext_req_i,
  input  logic          bus_rdy_i,
  input  logic [DW-1:0] rd_unit_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] hold_o,
  output logic          unit_done_o,
  output logic          busy_o
);

  xfer_st_e      state_q, state_d;
  logic          pend_q, req_q, rise, launch;
  logic [DW-1:0] hold_q;

  assign rise   = ext_req_i && !req_q;
  assign launch = (state_q == ST_ARM) && enable_i && (!steal_i || pend_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ARM;
      ST_ARM:  if (!enable_i) state_d = ST_IDLE;
               else if (launch) state_d = ST_RD;
      ST_RD:   if (bus_rdy_i) state_d = ST_WR;
      ST_WR:   if (bus_rdy_i) state_d = last_i ? ST_IDLE : ST_ARM;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= ext_req_i;
      if (start_i)               pend_q <= 1'b0;
      else if (launch && steal_i) pend_q <= rise;
      else if (rise)              pend_q <= 1'b1;
      if (state_q == ST_RD && bus_rdy_i) hold_q <= rd_unit_i;
    end
  end

  assign bus_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_we_o    = (state_q == ST_WR);
  assign bus_addr_o  = (state_q == ST_WR) ? dst_i : src_i;
  assign hold_o      = hold_q;
  assign unit_done_o = (state_q == ST_WR) && bus_rdy_i;
  assign busy_o      = (state_q != ST_IDLE);

  // R2: a stalled cycle keeps address and direction
  assert_bus_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_rdy_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  // R2: a write cycle only follows a completed read cycle
  assert_rd_then_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_req_o && !bus_we_o && bus_rdy_i));

  // R8: without a pending request no unit is launched in cycle-steal mode
  assert_steal_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && steal_i && !pend_q) |=> !bus_req_o);

endmodule

// File: rtl/dma_dual_chan.sv
module dma_dual_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            ext_req_i,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW/8-1:0] bus_be_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  input  logic            bus_rdy_i,
  output logic            irq_o
);

  localparam int NL = DW / 8;
  localparam int LW = (NL > 1) ? $clog2(NL) : 1;

  logic [AW-1:0] src, dst;
  mode_t         mode;
  logic          start, last, err, busy, unit_done;
  logic [DW-1:0] rd_unit, hold;

  dma_cfg_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_i      (busy),
    .unit_done_i (unit_done),
    .src_o       (src),
    .dst_o       (dst),
    .mode_o      (mode),
    .start_o     (start),
    .last_o      (last),
    .err_o       (err),
    .irq_o       (irq_o)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .enable_i    (mode.enable),
    .steal_i     (mode.steal),
    .last_i      (last),
    .src_i       (src),
    .dst_i       (dst),
    .ext_req_i   (ext_req_i),
    .bus_rdy_i   (bus_rdy_i),
    .rd_unit_i   (rd_unit),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .hold_o      (hold),
    .unit_done_o (unit_done),
    .busy_o      (busy)
  );

  dma_lane_align #(.DW(DW)) u_align (
    .size_i      (mode.size),
    .rd_lane_i   (src[LW-1:0]),
    .wr_lane_i   (dst[LW-1:0]),
    .bus_rdata_i (bus_rdata_i),
    .hold_i      (hold),
    .rd_unit_o   (rd_unit),
    .wdata_o     (bus_wdata_o),
    .be_o        (bus_be_o)
  );

  // R7: a configuration error never coexists with bus activity
  assert_err_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> !bus_req_o);

  // R4: write enables cover exactly one unit
  assert_be_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> ($countones(bus_be_o) == int'(unit_bytes(mode.size))));

endmodule

// File: tb/dma_dual_chan_tb_top.sv
`timescale 1ns/1ps
module dma_dual_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_req = 1'b0;
  logic        bus_req, bus_we, bus_rdy;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int waits = 0;
  int wcnt  = 0;

  logic [31:0] mem [64];
  logic [31:0] log_addr [256];
  logic        log_we   [256];
  logic [3:0]  log_be   [256];
  logic [31:0] log_wd   [256];
  int          log_n = 0;

  always #4 clk = ~clk;

  dma_dual_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ext_req_i(ext_req),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_be_o(bus_be),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy), .irq_o(irq)
  );

  assign bus_rdy   = bus_req && (wcnt >= waits);
  assign bus_rdata = mem[bus_addr[7:2]];

  always @(posedge clk) begin
    if (bus_req && !bus_rdy) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (bus_req && bus_rdy) begin
      if (bus_we)
        for (int k = 0; k < 4; k++)
          if (bus_be[k]) mem[bus_addr[7:2]][8*k +: 8] <= bus_wdata[8*k +: 8];
      if (log_n < 256) begin
        log_addr[log_n] <= bus_addr;
        log_we[log_n]   <= bus_we;
        log_be[log_n]   <= bus_be;
        log_wd[log_n]   <= bus_wdata;
        log_n           <= log_n + 1;
      end
    end
  end

  function automatic logic [7:0] byte_at(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  function automatic logic [31:0] word_at(input logic [7:0] a);
    return {byte_at(a + 8'd3), byte_at(a + 8'd2), byte_at(a + 8'd1), byte_at(a)};
  endfunction

  task automatic mem_init();
    for (int i = 0; i < 64; i++) mem[i] = word_at(8'(i * 4));
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd_reg(3'd4, s);
      if (s[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); ext_req = 1'b1;
    repeat (3) @(negedge clk);
    ext_req = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr_reg(3'd4, 32'h1);
    wr_reg(3'd0, s);
    wr_reg(3'd1, d);
    wr_reg(3'd2, c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 bus_req after reset", {31'h0, bus_req}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_word_block();
    int base; logic [31:0] v;
    mem_init(); waits = 0;
    setup(32'h10, 32'h80, 32'd16);
    base = log_n;
    wr_reg(3'd3, 32'h4C);
    wait_done();
    for (int j = 0; j < 4; j++) chk("R3 word copy", mem[32 + j], word_at(8'(16 + 4 * j)));
    chk("R2 cycle count", 32'(log_n - base), 32'd8);
    chk("R2 first read addr", log_addr[base], 32'h10);
    chk("R2 first is read", {31'h0, log_we[base]}, 32'h0);
    chk("R2 then write addr", log_addr[base + 1], 32'h80);
    chk("R2 then is write", {31'h0, log_we[base + 1]}, 32'h1);
    rd_reg(3'd2, v); chk("R5 count ends zero", v, 32'h0);
    rd_reg(3'd0, v); chk("R3 src advanced by 4/unit", v, 32'h20);
    rd_reg(3'd1, v); chk("R3 dst advanced by 4/unit", v, 32'h90);
    rd_reg(3'd4, v); chk("R5 done set", v, 32'h1);
    chk("R10 irq off when disabled", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_byte_static();
    int base; logic [31:0] v; logic [7:0] b;
    mem_init(); waits = 2;
    setup(32'h41, 32'h82, 32'd3);
    base = log_n;
    wr_reg(3'd3, 32'h45);
    wait_done();
    chk("R2 stretched cycle count", 32'(log_n - base), 32'd6);
    for (int j = 0; j < 3; j++) begin
      b = byte_at(8'(8'h41 + j));
      chk("R3 static dst addr", log_addr[base + 2 * j + 1], 32'h82);
      chk("R4 byte enables lane 2", {28'h0, log_be[base + 2 * j + 1]}, 32'h4);
      chk("R4 byte replicated", log_wd[base + 2 * j + 1], {b, b, b, b});
    end
    chk("R4 other lanes untouched", mem[32],
        {byte_at(8'h83), byte_at(8'h43), byte_at(8'h81), byte_at(8'h80)});
    rd_reg(3'd0, v); chk("R3 src advanced by 1/unit", v, 32'h44);
    rd_reg(3'd1, v); chk("R3 static dst unchanged", v, 32'h82);
    waits = 0;
  endtask

  task automatic t_half_cross();
    int base; logic [15:0] h;
    mem_init(); waits = 1;
    setup(32'h22, 32'hA2, 32'd4);
    base = log_n;
    wr_reg(3'd3, 32'h4E);
    wait_done();
    h = {byte_at(8'h23), byte_at(8'h22)};
    chk("R4 half upper lanes be", {28'h0, log_be[base + 1]}, 32'hC);
    chk("R4 half replicated", log_wd[base + 1], {h, h});
    chk("R4 half to upper lanes", mem[40], {h, byte_at(8'hA1), byte_at(8'hA0)});
    chk("R4 half to lower lanes", mem[41],
        {byte_at(8'hA7), byte_at(8'hA6), byte_at(8'h25), byte_at(8'h24)});
    chk("R4 half lower be", {28'h0, log_be[base + 3]}, 32'h3);
    waits = 0;
  endtask

  task automatic err_case(input string tag, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [31:0] m);
    int base; logic [31:0] v;
    setup(s, d, c);
    base = log_n;
    wr_reg(3'd3, m);
    repeat (6) @(negedge clk);
    rd_reg(3'd4, v); chk(tag, v, 32'h2);
    chk("R7 no bus cycle on error", 32'(log_n - base), 32'd0);
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, v); chk("R10 status write clears error", v, 32'h0);
  endtask

  task automatic t_cfg_err();
    mem_init();
    err_case("R7 size code 3",          32'h00, 32'h80, 32'd4, 32'h4F);
    err_case("R7 count not multiple",   32'h00, 32'h80, 32'd3, 32'h4E);
    err_case("R7 misaligned source",    32'h11, 32'h80, 32'd4, 32'h4C);
    err_case("R7 misaligned dest",      32'h00, 32'h82, 32'd4, 32'h4C);
    err_case("R7 zero count",           32'h00, 32'h80, 32'd0, 32'h45);
  endtask

  task automatic t_count_width();
    logic [31:0] v;
    wr_reg(3'd2, 32'hFF00_0010);
    rd_reg(3'd2, v); chk("R6 upper count bits ignored", v, 32'h10);
  endtask

  task automatic t_steal();
    int base; logic [31:0] v;
    mem_init();
    setup(32'h00, 32'h84, 32'd8);
    base = log_n;
    wr_reg(3'd3, 32'h54);
    repeat (10) @(negedge clk);
    chk("R8 no unit without request", 32'(log_n - base), 32'd0);
    rd_reg(3'd4, v); chk("R8 busy while armed", v, 32'h4);
    pulse_req();
    repeat (10) @(negedge clk);
    chk("R8 one unit per request", 32'(log_n - base), 32'd2);
    rd_reg(3'd2, v); chk("R5 count after one unit", v, 32'd4);
    pulse_req();
    wait_done();
    chk("R8 second request one unit", 32'(log_n - base), 32'd4);
    chk("R8 static dst holds last word", mem[33], word_at(8'h04));
    rd_reg(3'd4, v); chk("R5 done after steal block", v, 32'h1);
  endtask

  task automatic t_stop();
    int base; logic [31:0] v;
    mem_init();
    setup(32'h00, 32'h90, 32'd12);
    base = log_n;
    wr_reg(3'd3, 32'h5C);
    pulse_req();
    repeat (10) @(negedge clk);
    rd_reg(3'd2, v); chk("R9 one unit before stop", v, 32'd8);
    wr_reg(3'd3, 32'h1C);
    repeat (2) @(negedge clk);
    rd_reg(3'd4, v); chk("R9 stopped not done", v, 32'h0);
    pulse_req();
    repeat (10) @(negedge clk);
    chk("R9 no data after stop", 32'(log_n - base), 32'd2);
    rd_reg(3'd2, v); chk("R9 count frozen", v, 32'd8);
  endtask

  task automatic t_busy_writes();
    logic [31:0] v;
    setup(32'h00, 32'h90, 32'd4);
    wr_reg(3'd3, 32'h5C);
    wr_reg(3'd0, 32'h40);
    wr_reg(3'd1, 32'h44);
    wr_reg(3'd2, 32'h100);
    rd_reg(3'd0, v); chk("R11 src write ignored while busy", v, 32'h0);
    rd_reg(3'd1, v); chk("R11 dst write ignored while busy", v, 32'h90);
    rd_reg(3'd2, v); chk("R11 count write ignored while busy", v, 32'd4);
    wr_reg(3'd3, 32'h00);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    mem_init();
    setup(32'h00, 32'hB0, 32'd4);
    wr_reg(3'd3, 32'h6C);
    chk("R10 irq low before done", {31'h0, irq}, 32'h0);
    wait_done();
    chk("R10 irq raised on done", {31'h0, irq}, 32'h1);
    wr_reg(3'd4, 32'h1);
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);
    rd_reg(3'd4, v); chk("R10 done cleared", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mem_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_block();
    t_byte_static();
    t_half_cross();
    t_cfg_err();
    t_count_width();
    t_steal();
    t_stop();
    t_busy_writes();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule